// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Operand Gating

This block is a purely combinational arithmetic-logic unit. It is built from a row of identical one-bit slices, and the width is set by a parameter that defaults to 8. Each slice receives one bit of each operand. Two enable inputs can force either operand to zero, and a third control can then complement the first operand. The conditioned bits feed a small logic unit and a full adder.

A two-bit function code is decoded inside every slice into four one-hot select lines. Those lines choose one of four results for the slice output:
- bitwise AND
- bitwise OR
- complement of the second operand
- adder sum

The carry ripples from the least significant slice to the most significant. The carry into slice 0 comes from a seed input. Useful results such as zero, increment, two's-complement negation and subtraction come from combining the gating, inversion and seed controls, not from separate function codes.

Top module: `sliced_ripple_alu`

## Requirements
In these requirements, A' = (a_en ? op_a : 0) XOR {W{a_inv}} and B' = (b_en ? op_b : 0).
- R1: Each slice turns func into four select lines, exactly one of which is active for every code.
- R2: func = 2'b00 gives result = A' & B'.
- R3: func = 2'b01 gives result = A' | B'.
- R4: func = 2'b10 gives result = ~B'.
- R5: func = 2'b11 gives {carry_out, result} = A' + B' + carry_seed, with the carry rippling slice to slice.
- R6: a_en = 0 forces the first operand to zero before inversion, and b_en = 0 forces the second operand to zero; the masked operand bits then have no effect on result.
- R7: a_in = 1 complements the gated first operand before both the logic unit and the adder.
- R8: For func values other than 2'b11, carry_out is 0 and carry_seed has no effect on result.
- R9: Control combinations give derived operations under func = 2'b11:
  - a_en=1, b_en=0, a_inv=1, carry_seed=1 gives -op_a.
  - a_en=1, b_en=1, a_inv=1, carry_seed=1 gives op_b - op_a.
  - a_en=1, b_en=0, a_inv=0, carry_seed=1 gives op_a + 1.
  - a_en=0, b_en=1, a_inv=1, carry_seed=1 gives op_b with carry_out = 1.
  - a_en=0, b_en=0, a_inv=0, carry_seed=0 gives 0.
- R10: A carry entering slice 0 can propagate through every slice to carry_out; for example 8'hFF + 8'h00 + 1 gives result 0 and carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W (8) | First operand |
| op_b | input | W (8) | Second operand |
| func | input | 2 | Function code: 00 AND, 01 OR, 10 NOT B, 11 sum |
| a_en | input | 1 | Pass first operand when 1; force it to zero when 0 |
| b_en | input | 1 | Pass second operand when 1; force it to zero when 0 |
| a_inv | input | 1 | Complement the gated first operand |
| carry_seed | input | 1 | Carry into the least significant slice |
| result | output | W (8) | Function result |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The hardest case to reach from the ports is a carry that travels through all slices. Random operands seldom make every bit position propagate, so the vector table includes all-ones plus a seed and complement-plus-one cases. A second hard case is the interaction of gating with inversion: a masked operand that is then complemented must act as all ones. The bench reaches it by sweeping all sixteen settings of the four controls under every function code with random operands, and compares each result with a reference model built from the requirements.

// File: rtl/sliced_alu_pkg.sv
package sliced_alu_pkg;
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_SUM  = 2'b11
    } alu_fn_e;

    localparam int NUM_FN = 4;
endpackage

// File: rtl/fn_onehot_decoder.sv
module fn_onehot_decoder
    import sliced_alu_pkg::*;
(
    input  logic [1:0]        code_i,
    output logic [NUM_FN-1:0] sel_o
);
    always_comb begin
        sel_o = '0;
        unique case (alu_fn_e'(code_i))
            FN_AND:  sel_o[FN_AND]  = 1'b1;
            FN_OR:   sel_o[FN_OR]   = 1'b1;
            FN_NOTB: sel_o[FN_NOTB] = 1'b1;
            FN_SUM:  sel_o[FN_SUM]  = 1'b1;
            default: sel_o = '0;
        endcase
    end

    always_comb begin
        // R1
        onehot_sel_chk: assert ($countones(sel_o) == 1)
            else $error("decoder select not one-hot");
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import sliced_alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic [1:0] func_i,
    input  logic       a_en_i,
    input  logic       b_en_i,
    input  logic       a_inv_i,
    output logic       y_o,
    output logic       cout_o
);
    logic [NUM_FN-1:0] sel;
    logic              a_gated, b_gated, a_cond;
    logic              and_v, or_v, notb_v, sum_v, carry_gen;

    fn_onehot_decoder dec_i (
        .code_i (func_i),
        .sel_o  (sel)
    );

    always_comb begin
        a_gated   = a_i & a_en_i;
        b_gated   = b_i & b_en_i;
        a_cond    = a_gated ^ a_inv_i;
        and_v     = a_cond & b_gated;
        or_v      = a_cond | b_gated;
        notb_v    = ~b_gated;
        sum_v     = a_cond ^ b_gated ^ cin_i;
        carry_gen = (a_cond & b_gated) | (cin_i & (a_cond ^ b_gated));
        y_o       = |(sel & {sum_v, notb_v, or_v, and_v});
        cout_o    = sel[FN_SUM] & carry_gen;
    end

    always_comb begin
        // R8
        nonsum_carry_chk: assert (func_i == FN_SUM || cout_o == 1'b0)
            else $error("carry out active for a logic function");
        // R6
        masked_and_chk: assert (!(func_i == FN_AND && !a_en_i && !a_inv_i) || y_o == 1'b0)
            else $error("masked operand leaked into AND");
        // R5
        slice_add_chk: assert (func_i != FN_SUM ||
            {cout_o, y_o} == 2'(((a_i & a_en_i) ^ a_inv_i)) + 2'(b_i & b_en_i) + 2'(cin_i))
            else $error("slice sum mismatch");
    end
endmodule

// File: rtl/sliced_ripple_alu.sv
module sliced_ripple_alu
    import sliced_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   func,
    input  logic         a_en,
    input  logic         b_en,
    input  logic         a_inv,
    input  logic         carry_seed,
    output logic [W-1:0] result,
    output logic         carry_out
);
    localparam int CHAIN = W + 1;

    logic [CHAIN-1:0] chain;

    assign chain[0] = carry_seed;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_bit_slice slice_i (
            .a_i     (op_a[i]),
            .b_i     (op_b[i]),
            .cin_i   (chain[i]),
            .func_i  (func),
            .a_en_i  (a_en),
            .b_en_i  (b_en),
            .a_inv_i (a_inv),
            .y_o     (result[i]),
            .cout_o  (chain[i+1])
        );
    end

    assign carry_out = chain[W];

    always_comb begin
        // R5
        word_sum_chk: assert (func != FN_SUM ||
            {carry_out, result} == (W+1)'((a_en ? op_a : '0) ^ {W{a_inv}}) +
                                   (W+1)'(b_en ? op_b : '0) + (W+1)'(carry_seed))
            else $error("word sum mismatch");
        // R4
        notb_word_chk: assert (func != FN_NOTB || result == ~(b_en ? op_b : '0))
            else $error("NOT B mismatch");
    end
endmodule

// File: tb/sliced_ripple_alu_tb_top.sv
module sliced_ripple_alu_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [1:0]   func = 2'b00;
    logic         a_en = 1'b0, b_en = 1'b0, a_inv = 1'b0, carry_seed = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    int           n_chk = 0, n_fail = 0;
    logic         done = 1'b0;

    always #2.5 clk = ~clk;

    sliced_ripple_alu #(.W(W)) dut_i (
        .op_a(op_a), .op_b(op_b), .func(func), .a_en(a_en), .b_en(b_en),
        .a_inv(a_inv), .carry_seed(carry_seed), .result(result), .carry_out(carry_out)
    );

    // fields: func[30:29] a_en[28] b_en[27] a_inv[26] seed[25] a[24:17] b[16:9] res[8:1] co[0]
    localparam int NV = 15;
    localparam logic [30:0] VEC [NV] = '{
        {2'b00, 4'b1100, 8'hCA, 8'h5F, 8'h4A, 1'b0},  // R2 AND
        {2'b01, 4'b1100, 8'hCA, 8'h5F, 8'hDF, 1'b0},  // R3 OR
        {2'b10, 4'b1100, 8'hCA, 8'h5F, 8'hA0, 1'b0},  // R4 NOT B
        {2'b11, 4'b1100, 8'hCA, 8'h5F, 8'h29, 1'b1},  // R5 sum with carry
        {2'b11, 4'b1011, 8'h05, 8'h77, 8'hFB, 1'b0},  // R9 negate A
        {2'b11, 4'b1011, 8'h00, 8'h77, 8'h00, 1'b1},  // R9 negate zero
        {2'b11, 4'b0111, 8'h33, 8'h05, 8'h05, 1'b1},  // R9 gated A inverted plus seed gives B
        {2'b11, 4'b1111, 8'h10, 8'h30, 8'h20, 1'b1},  // R9 B minus A
        {2'b11, 4'b1001, 8'h7F, 8'hAA, 8'h80, 1'b0},  // R9 increment A
        {2'b11, 4'b1101, 8'hFF, 8'h00, 8'h00, 1'b1},  // R10 full ripple
        {2'b00, 4'b1101, 8'hFF, 8'hFF, 8'hFF, 1'b0},  // R8 seed ignored by AND
        {2'b11, 4'b0000, 8'hAA, 8'h55, 8'h00, 1'b0},  // R9 zero
        {2'b10, 4'b1000, 8'h00, 8'h12, 8'hFF, 1'b0},  // R6 B masked
        {2'b00, 4'b1110, 8'h0F, 8'hFF, 8'hF0, 1'b0},  // R7 inverted A in AND
        {2'b01, 4'b0100, 8'hF0, 8'h0C, 8'h0C, 1'b0}   // R6 A masked in OR
    };

    task automatic check(input logic [W-1:0] er, input logic ec, input string req);
        n_chk++;
        if (result !== er || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s: result=%h co=%b expected result=%h co=%b func=%b ctl=%b%b%b%b a=%h b=%h",
                     req, result, carry_out, er, ec, func, a_en, b_en, a_inv, carry_seed, op_a, op_b);
        end
    endtask

    function automatic logic [W:0] model(input logic [1:0] f, input logic ae, be, ai, cs,
                                         input logic [W-1:0] a, b);
        logic [W-1:0] ap, bp;
        ap = (ae ? a : '0) ^ {W{ai}};
        bp = be ? b : '0;
        case (f)
            2'b00: model = {1'b0, ap & bp};
            2'b01: model = {1'b0, ap | bp};
            2'b10: model = {1'b0, ~bp};
            default: model = (W+1)'(ap) + (W+1)'(bp) + (W+1)'(cs);
        endcase
    endfunction

    initial begin
        logic [W:0] exp_v;
        // idle inputs all zero: AND of zeros
        @(negedge clk);
        check('0, 1'b0, "R2 idle");

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            {func, a_en, b_en, a_inv, carry_seed, op_a, op_b} = VEC[i][30:9];
            @(negedge clk);
            check(VEC[i][8:1], VEC[i][0], $sformatf("R1/vector %0d", i));
        end

        // R1 R2 R3 R4 R5 R6 R7 R8 sweep of controls under every function
        for (int f = 0; f < 4; f++) begin
            for (int c = 0; c < 16; c++) begin
                for (int r = 0; r < 8; r++) begin
                    @(posedge clk);
                    func = 2'(f);
                    {a_en, b_en, a_inv, carry_seed} = 4'(c);
                    op_a = W'($urandom);
                    op_b = W'($urandom);
                    exp_v = model(func, a_en, b_en, a_inv, carry_seed, op_a, op_b);
                    @(negedge clk);
                    check(exp_v[W-1:0], exp_v[W], "R2-R8 sweep");
                end
            end
        end

        // R8 seed toggled with fixed operands must not change a logic result
        for (int f = 0; f < 3; f++) begin
            @(posedge clk);
            func = 2'(f); {a_en, b_en, a_inv} = 3'b111; op_a = 8'h3C; op_b = 8'hA5;
            carry_seed = 1'b1;
            exp_v = model(func, 1'b1, 1'b1, 1'b1, 1'b0, op_a, op_b);
            @(negedge clk);
            check(exp_v[W-1:0], 1'b0, "R8 seed ignored");
        end
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 100000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule